// File: doc/BRIEF.md
# Touch key detection integrator

This block decides the state of one capacitive touch key from a stream of measurements. Once per completed acquisition burst it receives a signed 16-bit delta (reference minus raw signal, where a positive value means a finger is present). A sample counts as a touch when the delta is at or above a fixed threshold. A run of consecutive touching samples must agree before the key is declared pressed. A pressed key is released as soon as one sample falls below a lower release level, so the key has hysteresis.

The key output can follow the pressed state directly. It can also act as a flip-flop that changes state on each new press. A per-key stuck-key timer counts an externally supplied one-second tick while the key is pressed. When the selected limit is reached, the timer pulses a recalibration request for this channel only and clears the key's detection state. Baseline tracking is done elsewhere.

Top module: `touch_key_integrator`

## Requirements
- R1: A sample is a touch vote when the signed delta is at least 12. Negative deltas never vote.
- R2: While pressed, a sample with delta below 10 releases the key on that sample. A sample of 10 or 11 keeps the key pressed.
- R3: Each touching sample taken while not pressed advances a consensus count. Any non-touching sample taken before the count completes returns it to zero.
- R4: `detect` rises in the clock cycle after the sixth consecutive touching sample, and not earlier.
- R5: With `toggle_mode`=0, `key_out` equals `detect`.
- R6: The value of `timeout_sel` sets the stuck-key limit: 2'b00 gives 10 ticks, 2'b01 gives 60 ticks, and 2'b10 or 2'b11 gives no limit. When the limit-th `sec_tick` arrives while the key is pressed, `recal_req` is high for exactly one cycle and `detect` is low in that same cycle.
- R7: After a recalibration request, the consensus count and timer start from zero, so a new press needs six fresh touching samples.
- R8: With `toggle_mode`=1, `key_out` inverts once on each rising edge of `detect` and keeps its value on release. The limit is 10 ticks whatever `timeout_sel` holds.
- R9: With `toggle_mode`=1, a timeout does not change `key_out`.
- R10: If a sample and the expiring tick arrive in the same cycle, the expiry wins: the request is issued, `detect` clears, and the sample is dropped.
- R11: Ticks while the key is not pressed are not counted. Every press starts its timer at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sample_valid | input | 1 | One-cycle strobe: `delta` holds a new sample |
| delta | input | 16 | Signed reference-minus-signal value |
| sec_tick | input | 1 | One-cycle pulse once per second |
| timeout_sel | input | 2 | Stuck-key limit: 00 10 s, 01 60 s, 1x none |
| toggle_mode | input | 1 | 1 selects flip-flop output behaviour |
| key_out | output | 1 | Key output |
| detect | output | 1 | Key currently pressed |
| recal_req | output | 1 | One-cycle request to recalibrate this channel |

## Verification
The timer's expiry and a sample can land in the same cycle. The sample may be a releasing one or a touching one, so there are two cases to cover. The bench first holds the key pressed for one tick fewer than the limit. It then drives the final tick together with a sample of delta 0 in one case and delta 20 in the other. In both cases the bench expects `recal_req` high and `detect` low in the next cycle, and then six more touching samples before the key is pressed again.

// File: rtl/tki_pkg.sv
package tki_pkg;
  localparam logic [1:0] TO_SHORT = 2'b00;
  localparam logic [1:0] TO_LONG  = 2'b01;

  function automatic logic at_or_above(input int value, input int level);
    return value >= level;
  endfunction

  // stuck-key limit in ticks; 0 means no limit
  function automatic int limit_ticks(input logic [1:0] sel, input logic tog,
                                     input int short_s, input int long_s);
    if (tog) return short_s;
    case (sel)
      TO_SHORT: return short_s;
      TO_LONG:  return long_s;
      default:  return 0;
    endcase
  endfunction
endpackage

// File: rtl/tki_integrator.sv
module tki_integrator
  import tki_pkg::*;
#(
  parameter int DELTA_W = 16,
  parameter int THRESH  = 12,
  parameter int HYST    = 2,
  parameter int CONFIRM = 6
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      sample_valid,
  input  logic signed [DELTA_W-1:0] delta,
  input  logic                      clear,
  output logic                      det_q,
  output logic                      set_evt,
  output logic                      rel_evt
);
  localparam int CW          = $clog2(CONFIRM + 1);
  localparam int RELEASE_LVL = THRESH - HYST;

  logic [CW-1:0] cnt_q;
  logic hit, below_rel, last_vote;

  assign hit       = at_or_above(int'(delta), THRESH);
  assign below_rel = !at_or_above(int'(delta), RELEASE_LVL);
  assign last_vote = (int'(cnt_q) == CONFIRM - 1);
  assign set_evt   = sample_valid && !clear && !det_q && hit && last_vote;
  assign rel_evt   = sample_valid && !clear && det_q && below_rel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      det_q <= 1'b0;
      cnt_q <= '0;
    end else if (clear) begin
      det_q <= 1'b0;
      cnt_q <= '0;
    end else if (sample_valid) begin
      if (!det_q) begin
        if (!hit)          cnt_q <= '0;
        else if (last_vote) begin
          det_q <= 1'b1;
          cnt_q <= '0;
        end else           cnt_q <= cnt_q + CW'(1);
      end else if (below_rel) begin
        det_q <= 1'b0;
      end
    end
  end

  p_miss_resets_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sample_valid && !clear && !det_q && !hit |=> cnt_q == '0);

  p_rise_needs_run_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(det_q) |-> $past(sample_valid) && $past(hit) && ($past(int'(cnt_q)) == CONFIRM - 1));

  p_hold_band_r2: assert property (@(posedge clk) disable iff (!rst_n)
    det_q && sample_valid && !clear && !below_rel |=> det_q);
endmodule

// File: rtl/tki_ontimer.sv
module tki_ontimer #(
  parameter int LONG_SEC = 60,
  parameter int TW       = $clog2(LONG_SEC + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          active,
  input  logic          sec_tick,
  input  logic [TW-1:0] limit_s,
  output logic          expire
);
  logic [TW-1:0] tmr_q;

  assign expire = active && sec_tick && (limit_s != '0) &&
                  (int'(tmr_q) + 1 >= int'(limit_s));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    tmr_q <= '0;
    else if (!active || expire)    tmr_q <= '0;
    else if (sec_tick && tmr_q != '1) tmr_q <= tmr_q + TW'(1);
  end

  p_idle_timer_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> tmr_q == '0);
endmodule

// File: rtl/tki_keyout.sv
module tki_keyout (
  input  logic clk,
  input  logic rst_n,
  input  logic toggle_mode,
  input  logic det_q,
  input  logic set_evt,
  output logic key_out
);
  logic tog_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       tog_q <= 1'b0;
    else if (set_evt) tog_q <= ~tog_q;
  end

  assign key_out = toggle_mode ? tog_q : det_q;

  p_toggle_flip_r8: assert property (@(posedge clk) disable iff (!rst_n)
    set_evt |=> tog_q != $past(tog_q));

  p_toggle_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !set_evt |=> $stable(tog_q));
endmodule

// File: rtl/touch_key_integrator.sv
module touch_key_integrator
  import tki_pkg::*;
#(
  parameter int DELTA_W   = 16,
  parameter int THRESH    = 12,
  parameter int HYST      = 2,
  parameter int CONFIRM   = 6,
  parameter int SHORT_SEC = 10,
  parameter int LONG_SEC  = 60
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sample_valid,
  input  logic [DELTA_W-1:0] delta,
  input  logic               sec_tick,
  input  logic [1:0]         timeout_sel,
  input  logic               toggle_mode,
  output logic               key_out,
  output logic               detect,
  output logic               recal_req
);
  localparam int TW = $clog2(LONG_SEC + 1);

  logic          det_q, set_evt, rel_evt, expire, recal_q;
  logic [TW-1:0] limit_s;

  assign limit_s = TW'(limit_ticks(timeout_sel, toggle_mode, SHORT_SEC, LONG_SEC));

  tki_integrator #(.DELTA_W(DELTA_W), .THRESH(THRESH), .HYST(HYST), .CONFIRM(CONFIRM)) u_integ (
    .clk(clk), .rst_n(rst_n), .sample_valid(sample_valid), .delta($signed(delta)),
    .clear(expire), .det_q(det_q), .set_evt(set_evt), .rel_evt(rel_evt));

  tki_ontimer #(.LONG_SEC(LONG_SEC), .TW(TW)) u_timer (
    .clk(clk), .rst_n(rst_n), .active(det_q), .sec_tick(sec_tick),
    .limit_s(limit_s), .expire(expire));

  tki_keyout u_out (
    .clk(clk), .rst_n(rst_n), .toggle_mode(toggle_mode), .det_q(det_q),
    .set_evt(set_evt), .key_out(key_out));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) recal_q <= 1'b0;
    else        recal_q <= expire;
  end

  assign detect    = det_q;
  assign recal_req = recal_q;

  p_recal_drops_detect_r6: assert property (@(posedge clk) disable iff (!rst_n)
    recal_req |-> !detect);

  p_recal_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    recal_req |=> !recal_req);

  p_no_limit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !toggle_mode && timeout_sel[1] |=> !recal_req);

  p_toggle_kept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    recal_req && toggle_mode && $past(toggle_mode) |-> key_out == $past(key_out));

  p_release_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rel_evt |=> !detect);
endmodule

// File: tb/touch_key_integrator_bench.sv
module touch_key_integrator_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic sample_valid = 1'b0, sec_tick = 1'b0, toggle_mode = 1'b0;
  logic [15:0] delta = '0;
  logic [1:0]  timeout_sel = 2'b00;
  logic key_out, detect, recal_req;
  int   n_run = 0, n_fail = 0;
  bit   done = 0;

  always #10 clk = ~clk;

  touch_key_integrator u_touch_key_integrator (
    .clk(clk), .rst_n(rst_n), .sample_valid(sample_valid), .delta(delta),
    .sec_tick(sec_tick), .timeout_sel(timeout_sel), .toggle_mode(toggle_mode),
    .key_out(key_out), .detect(detect), .recal_req(recal_req));

  task automatic chk(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input logic sv, input int d, input logic tk);
    sample_valid = sv; delta = 16'(d); sec_tick = tk;
    @(negedge clk);
    sample_valid = 1'b0; sec_tick = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic press();
    for (int i = 0; i < 6; i++) step(1, 20, 0);
  endtask

  initial begin
    @(negedge clk);
    chk("R5 reset key_out", int'(key_out), 0);
    chk("R4 reset detect", int'(detect), 0);
    chk("R6 reset recal_req", int'(recal_req), 0);
    do_reset();

    // R1/R4: threshold sweep, six equal samples
    for (int d = -4; d <= 18; d++) begin
      do_reset();
      for (int i = 0; i < 5; i++) step(1, d, 0);
      chk($sformatf("R4 early d=%0d", d), int'(detect), 0);
      step(1, d, 0);
      chk($sformatf("R1 vote d=%0d", d), int'(detect), (d >= 12) ? 1 : 0);
    end
    do_reset();
    for (int i = 0; i < 6; i++) step(1, -32768, 0);
    chk("R1 most negative", int'(detect), 0);
    for (int i = 0; i < 6; i++) step(1, 32767, 0);
    chk("R1 most positive", int'(detect), 1);

    // R2/R5: release sweep
    for (int d = -5; d <= 14; d++) begin
      do_reset();
      press();
      step(1, d, 0);
      chk($sformatf("R2 release d=%0d", d), int'(detect), (d >= 10) ? 1 : 0);
      chk($sformatf("R5 follow d=%0d", d), int'(key_out), (d >= 10) ? 1 : 0);
    end

    // R3: a miss at each position restarts the count
    for (int p = 0; p < 6; p++) begin
      do_reset();
      for (int i = 0; i < p; i++) step(1, 30, 0);
      step(1, 3, 0);
      for (int i = 0; i < 5; i++) step(1, 30, 0);
      chk($sformatf("R3 miss at %0d", p), int'(detect), 0);
      step(1, 30, 0);
      chk($sformatf("R3 sixth after miss %0d", p), int'(detect), 1);
    end
    do_reset();
    for (int i = 0; i < 3; i++) begin step(1, 20, 0); step(0, 0, 0); end
    for (int i = 0; i < 3; i++) step(1, 20, 0);
    chk("R3 gaps without samples keep count", int'(detect), 1);

    // R6/R7/R8/R9: timeout per select and mode
    for (int tg = 0; tg < 2; tg++) begin
      for (int s = 0; s < 4; s++) begin
        int lim;
        int seen;
        lim = (tg == 1) ? 10 : (s == 0) ? 10 : (s == 1) ? 60 : 0;
        toggle_mode = logic'(tg); timeout_sel = 2'(s);
        do_reset();
        press();
        if (lim != 0) begin
          for (int i = 0; i < lim - 1; i++) step(0, 0, 1);
          chk($sformatf("R6 held before limit tg=%0d s=%0d", tg, s), int'(detect), 1);
          step(0, 0, 1);
          chk($sformatf("R6 recal tg=%0d s=%0d", tg, s), int'(recal_req), 1);
          chk($sformatf("R6 detect clear tg=%0d s=%0d", tg, s), int'(detect), 0);
          if (tg == 1) chk("R9 toggle kept on timeout", int'(key_out), 1);
          else         chk("R5 key drops on timeout", int'(key_out), 0);
          step(0, 0, 0);
          chk("R6 single pulse", int'(recal_req), 0);
          for (int i = 0; i < 5; i++) step(1, 20, 0);
          chk("R7 fresh count needed", int'(detect), 0);
          step(1, 20, 0);
          chk("R7 sixth sample presses", int'(detect), 1);
          if (tg == 1) chk("R8 toggle flips on new press", int'(key_out), 0);
        end else begin
          seen = 0;
          for (int i = 0; i < 70; i++) begin
            step(0, 0, 1);
            if (recal_req) seen++;
          end
          chk($sformatf("R6 no limit s=%0d recal", s), seen, 0);
          chk($sformatf("R6 no limit s=%0d detect", s), int'(detect), 1);
        end
      end
    end

    // R8: toggle over several presses
    toggle_mode = 1'b1; timeout_sel = 2'b10;
    do_reset();
    for (int k = 1; k <= 4; k++) begin
      press();
      chk($sformatf("R8 press %0d", k), int'(key_out), k % 2);
      step(1, 0, 0);
      chk($sformatf("R8 release %0d", k), int'(key_out), k % 2);
    end
    toggle_mode = 1'b0; timeout_sel = 2'b00;

    // R10: expiry together with a releasing and a touching sample
    for (int c = 0; c < 2; c++) begin
      do_reset();
      press();
      for (int i = 0; i < 9; i++) step(0, 0, 1);
      step(1, (c == 0) ? 0 : 20, 1);
      chk($sformatf("R10 recal case %0d", c), int'(recal_req), 1);
      chk($sformatf("R10 detect case %0d", c), int'(detect), 0);
      for (int i = 0; i < 5; i++) step(1, 20, 0);
      chk($sformatf("R10 sample dropped case %0d", c), int'(detect), 0);
    end

    // R11: idle ticks are ignored and each press restarts the timer
    do_reset();
    for (int i = 0; i < 25; i++) step(0, 0, 1);
    press();
    for (int i = 0; i < 9; i++) step(0, 0, 1);
    chk("R11 idle ticks ignored", int'(detect), 1);
    step(1, 0, 0);
    press();
    for (int i = 0; i < 9; i++) step(0, 0, 1);
    chk("R11 timer restarts per press", int'(recal_req) * 2 + int'(detect), 1);
    step(0, 0, 1);
    chk("R11 tenth tick expires", int'(recal_req), 1);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog (all requirements) actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule